// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Sequential Fetch Policy

This block resolves conditional branches in the decode stage of a five-stage in-order pipeline. Fetch never guesses a branch target: it always asks for the next sequential instruction. When a branch reaches decode, the resolver computes its target from the incremented PC and the offset, and it tests the branch condition on the two register operands. If the branch turns out to be taken, the fetch guess was wrong. The resolver then tells the PC logic to load the target, and it replaces the instruction that was fetched behind the branch with a no-op. A wrong guess therefore costs exactly one fetch slot.

The block contains the IF/ID pipeline latch, because a flush acts on that latch. It also contains two event counters that measure how often the sequential guess was right. The hazard unit drives a stall input when a branch operand is not yet available. While the stall is high, no branch is resolved, the latch holds its contents and the counters hold their values. Control and status pins are plain level signals. No streaming handshake is involved, because decode consumes one latch entry per unstalled cycle.

Top module: `br_resolve_decode`

## Requirements
- R1: `target_o` equals `id_pc_inc_i` plus the sign-extended 16-bit `id_offset_i` shifted left by two, modulo 2^32. It is computed combinationally in every cycle, whatever the branch kind.
- R2: The branch kind is encoded on `id_kind_i` as 0 = not a branch, 1 = branch if equal, 2 = branch if not equal, 3 = branch if greater than zero. Kind 0 never raises `redirect_o` or `flush_o`.
- R3: Kind 1 is taken exactly when `id_opa_i` equals `id_opb_i`. Kind 2 is taken exactly when they differ.
- R4: Kind 3 is taken exactly when `id_opa_i`, read as a signed two's-complement value, is strictly greater than zero. `id_opb_i` has no effect on its outcome.
- R5: `redirect_o` and `flush_o` are high, combinationally in the same cycle, exactly when a taken branch sits in decode and `stall_i` is low.
- R6: When `flush_o` is high at a rising edge, the latch loads the no-op word 32'h0000_0000 into `ifid_instr_o` and zero into `ifid_pc_inc_o`.
- R7: At a rising edge with neither a flush nor a stall, the latch captures `fetch_instr_i` and `fetch_pc_inc_i`. While `stall_i` is high, the latch holds its contents.
- R8: `branch_count_o` increases by one for each branch (kind 1 to 3) seen with `stall_i` low. `correct_count_o` increases by one for each such branch that is not taken. Both counters hold while `stall_i` is high, and a kind 0 cycle leaves both unchanged.
- R9: An active-low reset clears both counters and loads the no-op word and a zero PC into the latch. The counters wrap modulo 2^CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Decode stall from the hazard unit |
| id_kind_i | input | 2 | Branch kind of the instruction in decode |
| id_opa_i | input | DW | First register operand |
| id_opb_i | input | DW | Second register operand |
| id_offset_i | input | OW | Branch offset, in words |
| id_pc_inc_i | input | AW | Incremented PC of the branch |
| fetch_instr_i | input | IW | Instruction word from fetch |
| fetch_pc_inc_i | input | AW | Incremented PC from fetch |
| redirect_o | output | 1 | PC select: load the branch target |
| target_o | output | AW | Branch target address |
| flush_o | output | 1 | Flush of the IF/ID latch |
| ifid_instr_o | output | IW | Latched instruction |
| ifid_pc_inc_o | output | AW | Latched incremented PC |
| branch_count_o | output | CW | Count of resolved branches |
| correct_count_o | output | CW | Count of correct sequential guesses |

## Verification
The hardest cases to reach from the ports are a taken branch that coincides with a stall, and a counter that wraps in the middle of a run. The stall must suppress the flush and the count, and the wrap must give a small exact value. The bench sweeps every branch kind over all pairs from a set of boundary operands: zero, one, minus one, the most positive value, the most negative value and a small positive value. A stall is inserted on a fixed arithmetic pattern, so that taken, not-taken and non-branch cases each meet stalled cycles. The bench is built with a four-bit counter width, so both counters wrap many times during the sweep.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2,
    BK_GTZ  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
  parameter int DW = 32
) (
  input  brr_pkg::br_kind_e kind_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  output logic              is_branch_o,
  output logic              taken_o
);
  import brr_pkg::*;

  logic ops_equal;
  logic opa_positive;

  assign ops_equal    = (opa_i == opb_i);
  // strictly positive: sign bit clear and not all zeros
  assign opa_positive = !opa_i[DW-1] && (|opa_i);

  always_comb begin
    is_branch_o = 1'b1;
    taken_o     = 1'b0;
    unique case (kind_i)
      BK_EQ:   taken_o = ops_equal;
      BK_NE:   taken_o = !ops_equal;
      BK_GTZ:  taken_o = opa_positive;
      default: is_branch_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int SHIFT = 2
) (
  input  logic [AW-1:0] pc_inc_i,
  input  logic [OW-1:0] offset_i,
  output logic [AW-1:0] target_o
);
  localparam int EXT = AW - OW;

  logic [AW-1:0] offset_ext;
  logic [AW-1:0] byte_offset;

  generate
    if (EXT > 0) begin : g_extend
      assign offset_ext = {{EXT{offset_i[OW-1]}}, offset_i};
    end else begin : g_trunc
      assign offset_ext = offset_i[AW-1:0];
    end
  endgenerate

  assign byte_offset = offset_ext << SHIFT;
  assign target_o    = pc_inc_i + byte_offset;
endmodule

// File: rtl/br_event_counter.sv
module br_event_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (inc_i) begin
      count_o <= count_o + ONE;
    end
  end
endmodule

// File: rtl/br_ifid_latch.sv
module br_ifid_latch #(
  parameter int            IW       = 32,
  parameter int            AW       = 32,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          flush_i,
  input  logic [IW-1:0] instr_i,
  input  logic [AW-1:0] pc_inc_i,
  output logic [IW-1:0] instr_o,
  output logic [AW-1:0] pc_inc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_o  <= NOP_WORD;
      pc_inc_o <= '0;
    end else if (flush_i) begin
      instr_o  <= NOP_WORD;
      pc_inc_o <= '0;
    end else if (!hold_i) begin
      instr_o  <= instr_i;
      pc_inc_o <= pc_inc_i;
    end
  end
endmodule

// File: rtl/br_resolve_decode.sv
module br_resolve_decode #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            OW       = 16,
  parameter int            IW       = 32,
  parameter int            CW       = 16,
  parameter int            SHIFT    = 2,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic [1:0]    id_kind_i,
  input  logic [DW-1:0] id_opa_i,
  input  logic [DW-1:0] id_opb_i,
  input  logic [OW-1:0] id_offset_i,
  input  logic [AW-1:0] id_pc_inc_i,
  input  logic [IW-1:0] fetch_instr_i,
  input  logic [AW-1:0] fetch_pc_inc_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          flush_o,
  output logic [IW-1:0] ifid_instr_o,
  output logic [AW-1:0] ifid_pc_inc_o,
  output logic [CW-1:0] branch_count_o,
  output logic [CW-1:0] correct_count_o
);
  import brr_pkg::*;

  localparam int NCNT = 2;

  br_kind_e kind;
  logic     is_branch;
  logic     taken;
  logic     resolve;
  logic     mispredict;

  logic [NCNT-1:0]         cnt_inc;
  logic [NCNT-1:0][CW-1:0] cnt_val;

  assign kind = br_kind_e'(id_kind_i);

  br_cond_eval #(.DW(DW)) u_cond (
    .kind_i      (kind),
    .opa_i       (id_opa_i),
    .opb_i       (id_opb_i),
    .is_branch_o (is_branch),
    .taken_o     (taken)
  );

  br_target_calc #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_tgt (
    .pc_inc_i (id_pc_inc_i),
    .offset_i (id_offset_i),
    .target_o (target_o)
  );

  // A branch is resolved only when its operands are ready (no stall).
  assign resolve    = is_branch && !stall_i;
  assign mispredict = resolve && taken;
  assign redirect_o = mispredict;
  assign flush_o    = mispredict;

  br_ifid_latch #(.IW(IW), .AW(AW), .NOP_WORD(NOP_WORD)) u_ifid (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (stall_i),
    .flush_i  (mispredict),
    .instr_i  (fetch_instr_i),
    .pc_inc_i (fetch_pc_inc_i),
    .instr_o  (ifid_instr_o),
    .pc_inc_o (ifid_pc_inc_o)
  );

  // counter 0: every resolved branch; counter 1: resolved and not taken
  generate
    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      if (k == 0) begin : g_total
        assign cnt_inc[k] = resolve;
      end else begin : g_correct
        assign cnt_inc[k] = resolve && !taken;
      end
      br_event_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (cnt_inc[k]),
        .count_o (cnt_val[k])
      );
    end
  endgenerate

  assign branch_count_o  = cnt_val[0];
  assign correct_count_o = cnt_val[1];
endmodule

// File: rtl/br_resolve_decode_chk.sv
module br_resolve_decode_chk #(
  parameter int            AW       = 32,
  parameter int            IW       = 32,
  parameter int            CW       = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_i,
  input logic [1:0]    id_kind_i,
  input logic          redirect_o,
  input logic          flush_o,
  input logic [IW-1:0] ifid_instr_o,
  input logic [AW-1:0] ifid_pc_inc_o,
  input logic [CW-1:0] branch_count_o,
  input logic [CW-1:0] correct_count_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  a_r2_no_redirect_nonbranch: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind_i == 2'd0) |-> (!redirect_o && !flush_o));

  a_r5_stall_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !redirect_o);

  a_r6_flush_loads_nop: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (ifid_instr_o == NOP_WORD && ifid_pc_inc_o == '0));

  a_r7_stall_holds_latch: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(ifid_instr_o) && $stable(ifid_pc_inc_o)));

  a_r8_stall_holds_counts: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(branch_count_o) && $stable(correct_count_o)));

  a_r8_branch_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind_i != 2'd0 && !stall_i) |=> (branch_count_o == $past(branch_count_o) + ONE));

  a_r8_taken_not_correct: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> $stable(correct_count_o));

  a_r8_nonbranch_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind_i == 2'd0) |=> ($stable(branch_count_o) && $stable(correct_count_o)));
endmodule

bind br_resolve_decode br_resolve_decode_chk #(
  .AW(AW), .IW(IW), .CW(CW), .NOP_WORD(NOP_WORD)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .stall_i         (stall_i),
  .id_kind_i       (id_kind_i),
  .redirect_o      (redirect_o),
  .flush_o         (flush_o),
  .ifid_instr_o    (ifid_instr_o),
  .ifid_pc_inc_o   (ifid_pc_inc_o),
  .branch_count_o  (branch_count_o),
  .correct_count_o (correct_count_o)
);

// File: tb/tb_br_resolve_decode.sv
module tb_br_resolve_decode;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0;
  logic [1:0]  id_kind_i = '0;
  logic [31:0] id_opa_i = '0;
  logic [31:0] id_opb_i = '0;
  logic [15:0] id_offset_i = '0;
  logic [31:0] id_pc_inc_i = '0;
  logic [31:0] fetch_instr_i = '0;
  logic [31:0] fetch_pc_inc_i = '0;
  logic        redirect_o;
  logic [31:0] target_o;
  logic        flush_o;
  logic [31:0] ifid_instr_o;
  logic [31:0] ifid_pc_inc_o;
  logic [CW-1:0] branch_count_o;
  logic [CW-1:0] correct_count_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int unsigned m_branch  = 0;
  int unsigned m_correct = 0;
  logic [31:0] m_instr   = '0;
  logic [31:0] m_pc      = '0;

  logic [31:0] vals [6];
  logic [15:0] offs [8];

  always #10 clk = ~clk;

  br_resolve_decode #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .id_kind_i(id_kind_i),
    .id_opa_i(id_opa_i), .id_opb_i(id_opb_i), .id_offset_i(id_offset_i),
    .id_pc_inc_i(id_pc_inc_i), .fetch_instr_i(fetch_instr_i),
    .fetch_pc_inc_i(fetch_pc_inc_i), .redirect_o(redirect_o), .target_o(target_o),
    .flush_o(flush_o), .ifid_instr_o(ifid_instr_o), .ifid_pc_inc_o(ifid_pc_inc_o),
    .branch_count_o(branch_count_o), .correct_count_o(correct_count_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic [31:0] pc, input logic [31:0] fi,
                      input logic [31:0] fpc, input bit stall);
    logic        taken;
    logic        redir;
    logic [31:0] tgt;
    @(negedge clk);
    id_kind_i = kind; id_opa_i = a; id_opb_i = b; id_offset_i = off;
    id_pc_inc_i = pc; fetch_instr_i = fi; fetch_pc_inc_i = fpc; stall_i = stall;
    case (kind)
      2'd1: taken = (a == b);
      2'd2: taken = (a != b);
      2'd3: taken = ($signed(a) > 0);
      default: taken = 1'b0;
    endcase
    redir = taken && !stall;
    tgt = pc + ({{16{off[15]}}, off} << 2);
    #1;
    check(target_o == tgt, "R1 target", target_o, tgt);
    if (kind == 2'd0) check(!redirect_o && !flush_o, "R2 non-branch no redirect",
                            {31'd0, redirect_o}, 32'd0);
    else if (kind == 2'd3) check(redirect_o == redir, "R4 bgtz outcome",
                                 {31'd0, redirect_o}, {31'd0, redir});
    else check(redirect_o == redir, "R3 eq/ne outcome", {31'd0, redirect_o}, {31'd0, redir});
    check(flush_o == redir, "R5 flush with redirect", {31'd0, flush_o}, {31'd0, redir});
    if (redir) begin
      m_instr = 32'h0; m_pc = 32'h0;
    end else if (!stall) begin
      m_instr = fi; m_pc = fpc;
    end
    if (kind != 2'd0 && !stall) begin
      m_branch++;
      if (!taken) m_correct++;
    end
    @(posedge clk);
    #1;
    if (redir) check(ifid_instr_o == 32'h0 && ifid_pc_inc_o == 32'h0, "R6 flush nop",
                     ifid_instr_o, 32'h0);
    else check(ifid_instr_o == m_instr && ifid_pc_inc_o == m_pc, "R7 latch capture/hold",
               ifid_instr_o, m_instr);
    check(branch_count_o == CW'(m_branch), "R8 branch count",
          {28'd0, branch_count_o}, m_branch % 16);
    check(correct_count_o == CW'(m_correct), "R8 correct count",
          {28'd0, correct_count_o}, m_correct % 16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'hFFFF; offs[3] = 16'h7FFF;
    offs[4] = 16'h8000; offs[5] = 16'h0010; offs[6] = 16'hFFF0; offs[7] = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(ifid_instr_o == 32'h0 && ifid_pc_inc_o == 32'h0, "R9 reset latch", ifid_instr_o, 32'h0);
    check(branch_count_o == '0 && correct_count_o == '0, "R9 reset counts",
          {28'd0, branch_count_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      for (int ia = 0; ia < 6; ia++) begin
        for (int ib = 0; ib < 6; ib++) begin
          int idx;
          idx = k * 36 + ia * 6 + ib;
          step(2'(k), vals[ia], vals[ib], offs[idx % 8], 32'h0000_1000 + 32'(idx * 4) + 32'h7FFF_0000 * 32'(idx % 3),
               32'hA500_0000 + 32'(idx), 32'h0000_2000 + 32'(idx * 4), ((idx % 5) == 2));
        end
      end
    end
    // R4: bgtz ignores second operand
    step(2'd3, 32'd7, 32'd0, 16'h0002, 32'h100, 32'hBEEF0001, 32'h104, 1'b0);
    step(2'd3, 32'd7, 32'hFFFF_FFFF, 16'h0002, 32'h100, 32'hBEEF0002, 32'h104, 1'b0);
    // R9: counters wrapped after more than 2^CW branches
    check(m_branch > 16, "R9 wrap reached", m_branch, 17);
    check(branch_count_o == CW'(m_branch), "R9 counter wrap",
          {28'd0, branch_count_o}, m_branch % 16);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule